// File: doc/BRIEF.md
# Segmented DAC switch decoder

This block sits between a parallel sample bus and the switch array of a segmented current-steering DAC. On each rising clock edge it captures a 10-bit sample and splits the code into three fields. The top five bits drive 31 equal cells through a thermometer decoder. The next four bits drive 15 equal cells, each worth one sixteenth of a top cell, also through a thermometer decoder. The lowest bit drives one binary-weighted cell. Every cell has a complementary pair of steering lines, A and B. When a cell is on, exactly one of its two lines is active.

A coding input selects how the sample is read. In straight-binary mode the sample is used as it is. In two's-complement mode the top bit is inverted, which turns the signed sample into offset binary before decoding. A sleep input, captured on the same clock, turns every cell off so that neither line of any pair is active. The decoded switch lines are registered. A sample present at edge k therefore reaches the switch outputs just after edge k+1.

Top module: `segdac_switch_decoder`

## Requirements
- R1: The sample, the coding select and sleep are captured on a rising edge. The switch outputs reflect that capture after the following rising edge, which is one clock of latency, and a new sample can be accepted on every clock.
- R2: Decoded bits 9..5 form the upper field. Exactly that many `msb_a_o` lines are high, filled from index 0 upward with no gaps.
- R3: Decoded bits 4..1 form the middle field. Exactly that many `mid_a_o` lines are high, filled from index 0 upward with no gaps.
- R4: `lsb_a_o[0]` equals decoded bit 0.
- R5: With `coding_i`=0 the decoded code equals the sample. With `coding_i`=1 the decoded code is the sample with bit 9 inverted, so sample 0x200 decodes to 0 and sample 0x000 decodes to 0x200.
- R6: When not asleep, every B line is the inverse of its A line. Decoded code 0x3FF turns every A line on and every B line off.
- R7: When the captured sleep is 1, every A and B line is 0 whatever the sample. After sleep is released, the outputs show the first sample captured together with sleep low.
- R8: The active-low reset `rst_n` is synchronous. While it is low, and on the first update after it is released, the outputs show decoded code zero: all A lines 0 and all B lines 1.
- R9: Weight each active A line as follows: an upper cell counts 64, a middle cell counts 4 and the low cell counts 2. The weighted sum of the active A lines then equals twice the decoded code for every one of the 1024 codes in both coding modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| coding_i | input | 1 | 0 = straight binary, 1 = two's complement |
| sleep_i | input | 1 | 1 = turn all cells off |
| data_i | input | 10 | Sample, bit 9 most significant |
| msb_a_o | output | 31 | Upper cells, A steering lines |
| msb_b_o | output | 31 | Upper cells, B steering lines |
| mid_a_o | output | 15 | Middle cells, A steering lines |
| mid_b_o | output | 15 | Middle cells, B steering lines |
| lsb_a_o | output | 1 | Binary low cell, A steering line |
| lsb_b_o | output | 1 | Binary low cell, B steering line |

## Verification
The in-design properties compare the outputs with the inputs seen two edges earlier. They hold only once two consecutive edges have passed with reset high, and they assume the sample, coding and sleep inputs are settled at each rising edge. The bench keeps to this by changing every input on falling edges only and reading outputs on falling edges. It checks the output against the stimulus driven two falling edges before, so each sample has been captured and then registered. The full code sweep streams one new sample per clock. This exercises back-to-back captures as well as every thermometer count.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
   typedef enum logic {
      CODE_STRAIGHT = 1'b0,
      CODE_TWOS     = 1'b1
   } coding_e;

   typedef struct packed {
      logic       sleep;
      logic [9:0] code;
   } sample_t;
endpackage

// File: rtl/segdac_therm.sv
module segdac_therm #(
   parameter int IN_W = 5,
   localparam int CELLS = (1 << IN_W) - 1
) (
   input  logic [IN_W-1:0]  bin_i,
   output logic [CELLS-1:0] therm_o
);
   if (IN_W < 1 || IN_W > 8) begin : g_bad_w
      $error("segdac_therm: IN_W out of range");
   end

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      assign therm_o[i] = ({1'b0, bin_i} > (IN_W + 1)'(i));
   end
endmodule

// File: rtl/segdac_in_stage.sv
module segdac_in_stage #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coding_i,
   input  logic              sleep_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] code_o,
   output logic              sleep_o
);
   import segdac_pkg::*;

   logic [DATA_W-1:0] flip;
   logic [DATA_W-1:0] code_q;
   logic              sleep_q;

   // two's complement: invert top bit to reach offset binary (R5)
   always_comb begin
      flip = '0;
      if (coding_e'(coding_i) == CODE_TWOS) flip[DATA_W-1] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         sleep_q <= 1'b0;
      end else begin
         code_q  <= data_i ^ flip;
         sleep_q <= sleep_i;
      end
   end

   assign code_o  = code_q;
   assign sleep_o = sleep_q;

   assert_in_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (sleep_o == $past(sleep_i)));
endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder #(
   parameter int DATA_W = 10,
   parameter int HI_W   = 5,
   parameter int MID_W  = 4,
   localparam int LO_W      = DATA_W - HI_W - MID_W,
   localparam int HI_CELLS  = (1 << HI_W) - 1,
   localparam int MID_CELLS = (1 << MID_W) - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 coding_i,
   input  logic                 sleep_i,
   input  logic [DATA_W-1:0]    data_i,
   output logic [HI_CELLS-1:0]  msb_a_o,
   output logic [HI_CELLS-1:0]  msb_b_o,
   output logic [MID_CELLS-1:0] mid_a_o,
   output logic [MID_CELLS-1:0] mid_b_o,
   output logic [LO_W-1:0]      lsb_a_o,
   output logic [LO_W-1:0]      lsb_b_o
);
   if (LO_W < 1) begin : g_bad_split
      $error("segdac_switch_decoder: field widths exceed DATA_W");
   end

   logic [DATA_W-1:0]    code;
   logic                 asleep;
   logic [HI_CELLS-1:0]  hi_therm;
   logic [MID_CELLS-1:0] mid_therm;

   segdac_in_stage #(.DATA_W(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n), .coding_i(coding_i), .sleep_i(sleep_i),
      .data_i(data_i), .code_o(code), .sleep_o(asleep)
   );

   segdac_therm #(.IN_W(HI_W)) u_hi (
      .bin_i(code[DATA_W-1 -: HI_W]), .therm_o(hi_therm)
   );

   segdac_therm #(.IN_W(MID_W)) u_mid (
      .bin_i(code[LO_W +: MID_W]), .therm_o(mid_therm)
   );

   // output register with sleep gating and complementary steering (R6, R7)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msb_a_o <= '0;
         msb_b_o <= '1;
         mid_a_o <= '0;
         mid_b_o <= '1;
         lsb_a_o <= '0;
         lsb_b_o <= '1;
      end else if (asleep) begin
         msb_a_o <= '0;
         msb_b_o <= '0;
         mid_a_o <= '0;
         mid_b_o <= '0;
         lsb_a_o <= '0;
         lsb_b_o <= '0;
      end else begin
         msb_a_o <= hi_therm;
         msb_b_o <= ~hi_therm;
         mid_a_o <= mid_therm;
         mid_b_o <= ~mid_therm;
         lsb_a_o <= code[LO_W-1:0];
         lsb_b_o <= ~code[LO_W-1:0];
      end
   end

   // cycles since reset, saturating, used to qualify two-edge lookback
   logic [1:0] primed;
   always_ff @(posedge clk) begin
      if (!rst_n)              primed <= '0;
      else if (primed != 2'd2) primed <= primed + 2'd1;
   end

   function automatic logic [DATA_W-1:0] ref_code(input logic [DATA_W-1:0] d,
                                                  input logic c);
      ref_code = d;
      ref_code[DATA_W-1] = d[DATA_W-1] ^ c;
   endfunction

   assert_msb_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed == 2'd2 && !$past(sleep_i, 2)) |->
      ($countones(msb_a_o) ==
       int'(ref_code($past(data_i, 2), $past(coding_i, 2)) >> (DATA_W - HI_W))));

   assert_msb_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((msb_a_o & (msb_a_o + 1'b1)) == '0));

   assert_mid_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mid_a_o & (mid_a_o + 1'b1)) == '0));

   assert_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed == 2'd2 && !$past(sleep_i, 2)) |->
      ((msb_a_o ^ msb_b_o) == '1 && (mid_a_o ^ mid_b_o) == '1 &&
       (lsb_a_o ^ lsb_b_o) == '1));

   assert_sleep_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed == 2'd2 && $past(sleep_i, 2)) |->
      (msb_a_o == '0 && msb_b_o == '0 && mid_a_o == '0 && mid_b_o == '0 &&
       lsb_a_o == '0 && lsb_b_o == '0));

   assert_reset_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) == 1'b0) |->
      (msb_a_o == '0 && msb_b_o == '1 && mid_a_o == '0 && mid_b_o == '1));
endmodule

// File: tb/tb_segdac_switch_decoder.sv
`timescale 1ns/1ps
module tb_segdac_switch_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        coding = 1'b0;
   logic        sleep = 1'b0;
   logic [9:0]  data = '0;
   logic [30:0] msb_a, msb_b;
   logic [14:0] mid_a, mid_b;
   logic [0:0]  lsb_a, lsb_b;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   segdac_switch_decoder dut (
      .clk(clk), .rst_n(rst_n), .coding_i(coding), .sleep_i(sleep), .data_i(data),
      .msb_a_o(msb_a), .msb_b_o(msb_b), .mid_a_o(mid_a), .mid_b_o(mid_b),
      .lsb_a_o(lsb_a), .lsb_b_o(lsb_b)
   );

   // {coding, sleep, sample, expected decoded code}
   typedef struct packed {
      logic       cod;
      logic       slp;
      logic [9:0] smp;
      logic [9:0] exp_code;
   } vec_t;

   localparam vec_t VECS [0:8] = '{
      '{1'b0, 1'b0, 10'h3FF, 10'h3FF},
      '{1'b1, 1'b0, 10'h3FF, 10'h1FF},
      '{1'b1, 1'b0, 10'h200, 10'h000},
      '{1'b1, 1'b0, 10'h000, 10'h200},
      '{1'b0, 1'b0, 10'h021, 10'h021},
      '{1'b0, 1'b0, 10'h01E, 10'h01E},
      '{1'b0, 1'b0, 10'h2AA, 10'h2AA},
      '{1'b0, 1'b1, 10'h3FF, 10'h000},
      '{1'b1, 1'b0, 10'h155, 10'h355}
   };

   task automatic check_out(input logic [9:0] code, input logic slp, input string tag);
      logic [31:0] em;
      logic [15:0] ed;
      logic [30:0] xm_a, xm_b;
      logic [14:0] xd_a, xd_b;
      logic        xl_a, xl_b;
      int          wsum;
      em = (32'd1 << code[9:5]) - 32'd1;
      ed = (16'd1 << code[4:1]) - 16'd1;
      if (slp) begin
         xm_a = '0; xm_b = '0; xd_a = '0; xd_b = '0; xl_a = 1'b0; xl_b = 1'b0;
      end else begin
         xm_a = em[30:0]; xm_b = ~em[30:0];
         xd_a = ed[14:0]; xd_b = ~ed[14:0];
         xl_a = code[0];  xl_b = ~code[0];
      end
      wsum = 64 * $countones(msb_a) + 4 * $countones(mid_a) + 2 * int'(lsb_a[0]);
      n_run++;
      if (msb_a !== xm_a || msb_b !== xm_b || mid_a !== xd_a || mid_b !== xd_b ||
          lsb_a[0] !== xl_a || lsb_b[0] !== xl_b ||
          (!slp && wsum != 2 * int'(code))) begin
         n_fail++;
         $display("FAIL %s: got msb_a=%h msb_b=%h mid_a=%h mid_b=%h lsb=%b/%b sum=%0d, exp msb_a=%h msb_b=%h mid_a=%h mid_b=%h lsb=%b/%b sum=%0d",
                  tag, msb_a, msb_b, mid_a, mid_b, lsb_a[0], lsb_b[0], wsum,
                  xm_a, xm_b, xd_a, xd_b, xl_a, xl_b, slp ? 0 : 2 * int'(code));
      end
   endtask

   task automatic drive(input logic c, input logic s, input logic [9:0] d);
      coding = c; sleep = s; data = d;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [9:0] p1, p2;
      logic       c1, c2;
      // reset state (R8)
      repeat (3) @(negedge clk);
      check_out(10'h000, 1'b0, "R8 in reset");
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 10'h3FF);
      @(negedge clk);
      check_out(10'h000, 1'b0, "R8 first update after release");

      // table walk (R2 R3 R4 R5 R6 R7)
      foreach (VECS[i]) begin
         @(negedge clk);
         drive(VECS[i].cod, VECS[i].slp, VECS[i].smp);
         @(negedge clk);
         @(negedge clk);
         check_out(VECS[i].exp_code, VECS[i].slp, "R2 R3 R4 R5 R6 R7 table");
      end

      // streaming sweep of all codes in both modes, one per clock (R1 R9)
      for (int m = 0; m < 2; m++) begin
         p1 = '0; p2 = '0; c1 = 1'b0; c2 = 1'b0;
         for (int i = 0; i < 1026; i++) begin
            @(negedge clk);
            if (i >= 2) check_out(p2 ^ {c2, 9'd0}, 1'b0, "R1 R9 sweep");
            p2 = p1; c2 = c1;
            p1 = 10'(i); c1 = m[0];
            if (i < 1024) drive(m[0], 1'b0, 10'(i));
         end
      end

      // sleep override and release timing (R7 R1)
      @(negedge clk);
      drive(1'b0, 1'b1, 10'h3FF);
      @(negedge clk);
      @(negedge clk);
      check_out(10'h000, 1'b1, "R7 sleep with full-scale data");
      drive(1'b0, 1'b0, 10'h155);
      @(negedge clk);
      check_out(10'h000, 1'b1, "R7 R1 still off one edge after release");
      @(negedge clk);
      check_out(10'h155, 1'b0, "R7 resumes with next sample");

      // reset in mid-run (R8)
      drive(1'b0, 1'b0, 10'h3FF);
      @(negedge clk);
      @(negedge clk);
      check_out(10'h3FF, 1'b0, "R6 full scale before reset");
      rst_n = 1'b0;
      @(negedge clk);
      check_out(10'h000, 1'b0, "R8 mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_out(10'h000, 1'b0, "R8 after mid-run release");
      @(negedge clk);
      check_out(10'h3FF, 1'b0, "R1 capture after release");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule